// File: doc/BRIEF.md
# Controller Operating Mode Sequencer

This block owns the operating mode of a bus controller. Software writes a 16-bit control word over a small register bus. The word holds a requested mode, a sleep request and a set of configuration fields. A separate status word shows the mode that the controller has actually reached.

The requested mode and the reached mode are kept apart. A normal change of mode is acknowledged a fixed number of clocks after the request, which stands for the protocol engine reaching a bit boundary. Software therefore writes a mode and then polls the status word. A forced reset takes effect at once. The sleep request overrides the mode field. A bus-off event can move the controller to halt with no software action, when the recovery field asks for it.

The reached mode drives the outputs that gate the FIFOs and tell the rest of the controller whether it is in reset or asleep. The protocol engine and the bit-timing logic sit outside this block.

Top module: `mode_sequencer`

## Requirements
- R1: After reset the reached mode is sleep (`ack_mode` = 3, `in_sleep` = 1). The control word reads 0x0500, which is sleep bit 10 set and mode field 9:8 = 01. The status word reads 0x0400.
- R2: A change of mode other than a forced reset appears on `ack_mode` at the (ACK_LAT+1)-th rising edge after the edge that captured the request. On every edge before that, the old mode holds. With ACK_LAT = 4, a request driven in cycle C is seen in cycle C+6 and is not yet seen in cycle C+5.
- R3: The status word sets bit 8 while in reset, bit 9 while in halt, bit 10 while asleep and bit 11 while a change is pending. All other status bits read 0. `ack_mode` encodes operation as 0, reset as 1, halt as 2 and sleep as 3.
- R4: With sleep bit 10 clear, mode field 9:8 selects the target: 00 is operation, 01 is reset, 10 is halt and 11 is forced reset.
- R5: While in reset, writes reach the configuration fields: bit 0 (FIFO mailbox mode), bits 2:1 (ID format, 10 = mixed), bit 3 (overrun or overwrite on message loss) and bits 12:11 (bus-off recovery). Reserved bits always read 0.
- R6: Outside reset, writes to the configuration fields are ignored. Bits 10:8 stay writable in every mode.
- R7: When the recovery field is 01 and the controller is in operation, a pulse on `bus_off_evt` sets mode field 9:8 to 10, and halt is reached as in R2. With any other recovery value the pulse changes nothing.
- R8: A sleep request made in operation first brings the controller to halt, as in R2. The controller then reaches sleep ACK_LAT+1 edges later. It never goes straight from operation to sleep.
- R9: With sleep clear and mode field 11, the controller reaches reset on the first rising edge after the write, from any mode.
- R10: If the request returns to the current mode before the acknowledgement, the pending change is dropped and the reached mode never changes.
- R11: `fifo_en` is 1 exactly while the reached mode is operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control word, 1 = status word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on `bus_addr` |
| bus_off_evt | input | 1 | One-cycle pulse: the engine has entered bus-off |
| ack_mode | output | 2 | Reached mode (0 operation, 1 reset, 2 halt, 3 sleep) |
| in_reset | output | 1 | Reached mode is reset |
| in_sleep | output | 1 | Reached mode is sleep |
| fifo_en | output | 1 | FIFOs and engine may run (operation) |

## Verification
The hardest situation to reach is the two-stage path from operation to sleep. A single write must start a halt, wait for it to be acknowledged and then start a second timed change, while the configuration is locked. The stimulus gets there by taking the block out of sleep, configuring it in reset and running it in operation. It then writes the sleep bit, and the scoreboard checks the mode on the cycles just before and just after each of the two acknowledgements. A request withdrawn in mid-flight, and a bus-off pulse with and without automatic halt, are driven from the same running state.

// File: rtl/modeseq_pkg.sv
// Package: shared encodings and field positions of the mode sequencer.
// Assumes a 16-bit control word. Only bits named here exist.
package modeseq_pkg;
    typedef enum logic [1:0] {
        ACK_OPER  = 2'd0,
        ACK_RESET = 2'd1,
        ACK_HALT  = 2'd2,
        ACK_SLEEP = 2'd3
    } ack_mode_e;

    localparam int WORD_W    = 16;
    localparam int MODE_LO   = 8;
    localparam int SLEEP_BIT = 10;
    localparam int BOR_LO    = 11;

    // configuration fields: writable only in reset
    localparam logic [WORD_W-1:0] CFG_MASK   = 16'h180F;
    // sleep request and mode field: always writable
    localparam logic [WORD_W-1:0] LIVE_MASK  = 16'h0700;
    localparam logic [WORD_W-1:0] CTRL_RESET = 16'h0500;
    localparam logic [1:0]        BOR_AUTO_HALT = 2'b01;
    localparam logic [1:0]        REQ_HALT      = 2'b10;
    localparam logic [1:0]        REQ_FORCE     = 2'b11;
endpackage

// File: rtl/modeseq_ctrl_reg.sv
// Control word storage. The configuration fields take writes only while the
// reached mode is reset. A bus-off halt request overrides the mode field.
// Assumes wr_en is a single-cycle strobe.
module modeseq_ctrl_reg
    import modeseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              cfg_open,
    input  logic              force_halt,
    output logic [WORD_W-1:0] ctrl_q
);
    logic [WORD_W-1:0] wmask;
    logic [WORD_W-1:0] ctrl_d;

    // Next value: masked write, then bus-off override of the mode field
    always_comb begin
        wmask  = LIVE_MASK | (cfg_open ? CFG_MASK : '0);
        ctrl_d = ctrl_q;
        if (wr_en)
            ctrl_d = (ctrl_q & ~wmask) | (wdata & wmask);
        if (force_halt)
            ctrl_d[MODE_LO+1:MODE_LO] = REQ_HALT;
    end

    // Register update with synchronous reset into sleep
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= CTRL_RESET;
        else        ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/modeseq_fsm.sv
// Reached-mode tracker. It turns the requested mode into a target and waits
// ACK_LAT clocks of a steady target before acknowledging it. Forced reset
// skips the wait. Sleep requested in operation is routed through halt.
// Assumes ACK_LAT >= 1.
module modeseq_fsm
    import modeseq_pkg::*;
#(
    parameter int ACK_LAT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_req,
    input  logic       sleep_req,
    output ack_mode_e  cur,
    output logic       pending
);
    localparam int CNT_W = (ACK_LAT > 1) ? $clog2(ACK_LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACK_LAT - 1);

    ack_mode_e        tgt;
    ack_mode_e        pend;
    logic [CNT_W-1:0] cnt;
    logic             force_rst;

    // Target mode from the request bits and the mode already reached
    always_comb begin
        if (sleep_req)
            tgt = (cur == ACK_OPER) ? ACK_HALT : ACK_SLEEP;
        else begin
            case (mode_req)
                2'b00:   tgt = ACK_OPER;
                2'b10:   tgt = ACK_HALT;
                default: tgt = ACK_RESET;
            endcase
        end
        force_rst = !sleep_req && (mode_req == REQ_FORCE) && (cur != ACK_RESET);
    end

    // Settling counter and acknowledgement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= ACK_SLEEP;
            pend <= ACK_SLEEP;
            cnt  <= '0;
        end else if (force_rst) begin
            cur  <= ACK_RESET;
            pend <= ACK_RESET;
            cnt  <= '0;
        end else if (tgt == cur) begin
            pend <= cur;
            cnt  <= '0;
        end else if (tgt != pend) begin
            pend <= tgt;
            cnt  <= CNT_LOAD;
        end else if (cnt == '0) begin
            cur  <= pend;
        end else begin
            cnt  <= cnt - 1'b1;
        end
    end

    assign pending = (tgt != cur);
endmodule

// File: rtl/mode_sequencer.sv
// Top of the operating mode sequencer: register bus decode, control word,
// reached-mode tracker and mode outputs. Reads are combinational.
// Assumes bus_off_evt is a one-cycle pulse from the protocol engine.
module mode_sequencer
    import modeseq_pkg::*;
#(
    parameter int ACK_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              bus_off_evt,
    output logic [1:0]        ack_mode,
    output logic              in_reset,
    output logic              in_sleep,
    output logic              fifo_en
);
    logic [WORD_W-1:0] ctrl_q;
    logic [WORD_W-1:0] status;
    ack_mode_e         cur;
    logic              pending;
    logic              ctrl_wr;
    logic              busoff_halt;

    assign ctrl_wr     = bus_sel && bus_wr && !bus_addr;
    assign busoff_halt = bus_off_evt && (cur == ACK_OPER) &&
                         (ctrl_q[BOR_LO+1:BOR_LO] == BOR_AUTO_HALT);

    modeseq_ctrl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctrl_wr),
        .wdata      (bus_wdata),
        .cfg_open   (cur == ACK_RESET),
        .force_halt (busoff_halt),
        .ctrl_q     (ctrl_q)
    );

    modeseq_fsm #(.ACK_LAT(ACK_LAT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_req  (ctrl_q[MODE_LO+1:MODE_LO]),
        .sleep_req (ctrl_q[SLEEP_BIT]),
        .cur       (cur),
        .pending   (pending)
    );

    // Status word assembly and read mux
    always_comb begin
        status = {4'b0, pending, (cur == ACK_SLEEP), (cur == ACK_HALT),
                  (cur == ACK_RESET), 8'b0};
        bus_rdata = bus_addr ? status : ctrl_q;
    end

    assign ack_mode = cur;
    assign in_reset = (cur == ACK_RESET);
    assign in_sleep = (cur == ACK_SLEEP);
    assign fifo_en  = (cur == ACK_OPER);
endmodule

// File: rtl/modeseq_chk.sv
// Checker for the mode sequencer, bound into every instance of the top.
// It watches ports and the control word over time.
module modeseq_chk
    import modeseq_pkg::*;
#(
    parameter int ACK_LAT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_off_evt,
    input logic [1:0]        ack_mode,
    input logic              in_reset,
    input logic              in_sleep,
    input logic              fifo_en,
    input logic [WORD_W-1:0] ctrl_q
);
    localparam int AGE_W = $clog2(ACK_LAT + 1);

    logic [2:0]       req_d;
    logic [AGE_W-1:0] age;

    // Count how long the request bits 10:8 have stayed unchanged, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d <= CTRL_RESET[SLEEP_BIT:MODE_LO];
            age   <= '0;
        end else begin
            req_d <= ctrl_q[SLEEP_BIT:MODE_LO];
            if (ctrl_q[SLEEP_BIT:MODE_LO] != req_d) age <= '0;
            else if (age != AGE_W'(ACK_LAT))       age <= age + 1'b1;
        end
    end

    AST_WAKE_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ack_mode == ACK_SLEEP && in_sleep)); // R1

    AST_ACK_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_mode != $past(ack_mode) && !$past(!rst_n) &&
         !(in_reset && $past(ctrl_q[MODE_LO+1:MODE_LO]) == REQ_FORCE))
        |-> (age >= AGE_W'(ACK_LAT - 1))); // R2

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !in_reset |=> $stable(ctrl_q & CFG_MASK)); // R6

    AST_BUSOFF_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off_evt && fifo_en && ctrl_q[BOR_LO+1:BOR_LO] == BOR_AUTO_HALT)
        |=> (ctrl_q[MODE_LO+1:MODE_LO] == REQ_HALT)); // R7

    AST_NO_OPER_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fifo_en) |-> !in_sleep); // R8

    AST_FORCE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[SLEEP_BIT] && ctrl_q[MODE_LO+1:MODE_LO] == REQ_FORCE && !in_reset)
        |=> in_reset); // R9
endmodule

bind mode_sequencer modeseq_chk #(.ACK_LAT(ACK_LAT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_off_evt (bus_off_evt),
    .ack_mode    (ack_mode),
    .in_reset    (in_reset),
    .in_sleep    (in_sleep),
    .fifo_en     (fifo_en),
    .ctrl_q      (ctrl_q)
);

// File: tb/tb_mode_sequencer.sv
module tb_mode_sequencer;
    localparam int LAT = 4;
    localparam logic [1:0] M_OPER = 2'd0, M_RST = 2'd1, M_HALT = 2'd2, M_SLP = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_off_evt = 1'b0;
    logic [1:0]  ack_mode;
    logic        in_reset, in_sleep, fifo_en;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [1:0] mode;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mode_sequencer #(.ACK_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_off_evt(bus_off_evt), .ack_mode(ack_mode), .in_reset(in_reset),
        .in_sleep(in_sleep), .fifo_en(fifo_en)
    );

    // Monitor: compare the reached mode against queued expectations
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_tests++;
            if (ack_mode !== e.mode) begin
                n_fail++;
                $display("FAIL %s cyc %0d ack_mode=%0d expected=%0d", e.req, cyc, ack_mode, e.mode);
            end
        end
    end

    task automatic expect_mode(input int at, input logic [1:0] m, input string r);
        exp_t e;
        e.at = at; e.mode = m; e.req = r;
        sb.push_back(e);
    endtask

    task automatic drain();
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [15:0] v, output int c);
        @(negedge clk);
        c = cyc;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic pulse_busoff(output int c);
        @(negedge clk);
        c = cyc;
        bus_off_evt = 1'b1;
        @(negedge clk);
        bus_off_evt = 1'b0;
    endtask

    task automatic chk_rd(input logic a, input logic [15:0] exp, input string r);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        n_tests++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s read addr %0d got=%h expected=%h", r, a, bus_rdata, exp);
        end
        bus_sel = 1'b0;
    endtask

    task automatic chk_pins(input logic rs, input logic sl, input logic fe, input string r);
        @(negedge clk);
        n_tests++;
        if ({in_reset, in_sleep, fifo_en} !== {rs, sl, fe}) begin
            n_fail++;
            $display("FAIL %s pins got=%b expected=%b", r, {in_reset, in_sleep, fifo_en}, {rs, sl, fe});
        end
    endtask

    // Timed change: old mode one cycle before, new mode at C+LAT+2
    task automatic timed(input int c, input logic [1:0] old_m, input logic [1:0] new_m, input string r);
        expect_mode(c + LAT + 1, old_m, r);
        expect_mode(c + LAT + 2, new_m, r);
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        expect_mode(cyc + 1, M_SLP, "R1");
        drain();
        chk_rd(1'b0, 16'h0500, "R1");
        chk_rd(1'b1, 16'h0400, "R1");
        chk_pins(1'b0, 1'b1, 1'b0, "R1");

        // R2/R4: clear sleep, mode 01 -> reset after the settle time
        wr_ctrl(16'h0100, c);
        timed(c, M_SLP, M_RST, "R2");
        drain();
        chk_rd(1'b1, 16'h0100, "R3");
        chk_pins(1'b1, 1'b0, 1'b0, "R3");

        // R5: configuration in reset (fifo, mixed id, overrun, auto halt)
        wr_ctrl(16'h090D, c);
        chk_rd(1'b0, 16'h090D, "R5");
        wr_ctrl(16'hF1F0 | 16'h090D, c);
        chk_rd(1'b0, 16'h19FD & 16'h1F0F, "R5");
        wr_ctrl(16'h090D, c);

        // R4/R11: operation
        wr_ctrl(16'h080D, c);
        timed(c, M_RST, M_OPER, "R4");
        drain();
        chk_pins(1'b0, 1'b0, 1'b1, "R11");
        chk_rd(1'b1, 16'h0000, "R3");

        // R6: configuration writes ignored outside reset
        wr_ctrl(16'h0000, c);
        chk_rd(1'b0, 16'h080D, "R6");

        // R7: bus-off with auto halt
        pulse_busoff(c);
        timed(c, M_OPER, M_HALT, "R7");
        drain();
        chk_rd(1'b0, 16'h0A0D, "R7");
        chk_rd(1'b1, 16'h0200, "R3");

        // back to operation from halt
        wr_ctrl(16'h080D, c);
        timed(c, M_HALT, M_OPER, "R4");
        drain();

        // R8: sleep requested in operation goes through halt
        wr_ctrl(16'h0C0D, c);
        timed(c, M_OPER, M_HALT, "R8");
        expect_mode(c + 2*LAT + 2, M_HALT, "R8");
        expect_mode(c + 2*LAT + 3, M_SLP, "R8");
        drain();
        chk_rd(1'b1, 16'h0400, "R8");

        // R9: forced reset from sleep in one edge
        wr_ctrl(16'h0B0D, c);
        expect_mode(c + 1, M_SLP, "R9");
        expect_mode(c + 2, M_RST, "R9");
        drain();
        chk_rd(1'b0, 16'h0B0D, "R9");

        // R10: request withdrawn before acknowledgement
        wr_ctrl(16'h080D, c);
        expect_mode(c + LAT + 2, M_RST, "R10");
        expect_mode(c + 2*LAT, M_RST, "R10");
        wr_ctrl(16'h0B0D, c);
        drain();

        // R7: bus-off without auto halt has no effect
        wr_ctrl(16'h010D, c);
        chk_rd(1'b0, 16'h010D, "R5");
        wr_ctrl(16'h000D, c);
        timed(c, M_RST, M_OPER, "R4");
        drain();
        pulse_busoff(c);
        expect_mode(c + LAT + 2, M_OPER, "R7");
        expect_mode(c + 2*LAT + 2, M_OPER, "R7");
        drain();
        chk_rd(1'b0, 16'h000D, "R7");

        // R9: forced reset from operation
        wr_ctrl(16'h030D, c);
        expect_mode(c + 2, M_RST, "R9");
        drain();

        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule